// File: doc/BRIEF.md
# Parallel Frame Scrambler and Descrambler

This block whitens one serial channel's data with the additive sequence of the polynomial 1 + x^6 + x^7. It works on a 32-bit parallel word, so every valid clock consumes 32 consecutive sequence bits. That lets a channel at 2.488 Gbit/s be scrambled at a modest core clock, ahead of a later 32-to-8 width converter and the serializer. The sequence generator is reseeded to all ones on every word flagged as the start of a frame. Transmitter and receiver therefore stay aligned without any exchange of state.

The transmit path scrambles outgoing words. The receive path runs the same generator on incoming words, and because the scrambling is additive, the same operation restores the original data. A byte-lane skip mask keeps framing bytes unscrambled while the generator still steps across them. A channel bypass passes raw words through untouched. In that case the user's data must carry enough transitions for clock recovery. Both paths register their outputs and carry a valid flag alongside the data.

Top module: `frame_scrambler`

## Requirements
- R1: For a valid word with frame start, zero data and no lanes skipped, the output is 32'hFE041851. Each following valid word consumes the next 32 bits of the 127-bit sequence b(n) = b(n-7) xor b(n-6), with b(0) to b(6) equal to 1.
- R2: A valid word with frame start restarts the sequence from the all-ones seed, whatever state the generator held before.
- R3: Word bit 31 is combined with the earliest sequence bit of the word, and bit 0 with the latest. Byte lane 3 (bits 31:24) holds the first serial byte.
- R4: A cycle without valid neither advances the generator nor changes the data output.
- R5: When skip bit k is set, byte lane k (bits 8k+7:8k) passes unchanged. The generator still advances the full 32 bits for that word.
- R6: While bypass is high, the data output of both paths equals the data input of the cycle before. The generator keeps advancing on valid words.
- R7: The valid output equals the valid input of the previous cycle, so latency is one cycle.
- R8: Suppose the receive path is fed the transmit output, with the matching frame start and skip mask. Then the receive output equals the original transmit data.
- R9: While reset is low, both valid outputs and both data outputs are 0. After reset the generator holds the seed, so a first valid word without frame start, with zero data, gives 32'hFE041851.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | Channel raw mode, applies to both paths |
| tx_valid_i | input | 1 | Transmit word valid |
| tx_sof_i | input | 1 | Transmit word is the first of a frame |
| tx_skip_i | input | 4 | Transmit byte lanes exempt from scrambling |
| tx_data_i | input | 32 | Transmit word, bit 31 first in serial order |
| tx_valid_o | output | 1 | Scrambled word valid |
| tx_data_o | output | 32 | Scrambled word |
| rx_valid_i | input | 1 | Receive word valid |
| rx_sof_i | input | 1 | Receive word is the first of a frame |
| rx_skip_i | input | 4 | Receive byte lanes exempt from descrambling |
| rx_data_i | input | 32 | Received scrambled word |
| rx_valid_o | output | 1 | Descrambled word valid |
| rx_data_o | output | 32 | Descrambled word |

## Verification
Some rules are checked by assertions on every cycle in each path:
- the one-cycle valid latency;
- data holding and generator freezing on idle cycles;
- raw pass-through under bypass;
- untouched skipped lanes;
- the seed appearing as the first seven keystream bits of a frame-start word.

Other behaviour can only be shown by the bench's scenarios. This covers the actual sequence values, bit ordering, correct advancement across skipped lanes, bypassed words and idle gaps, mid-frame reseeding, and the loopback round trip. The bench compares them against a model that walks a precomputed 127-bit sequence by position.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SCR_WORD_W = 32;
  localparam int unsigned SCR_LANE_W = 8;
  localparam int unsigned SCR_LFSR_W = 7;
  // taps for x^7 and x^6, feedback shifted in at bit 0
  localparam logic [SCR_LFSR_W-1:0] SCR_TAPS = 7'b1100000;
  localparam logic [SCR_LFSR_W-1:0] SCR_SEED = 7'h7F;

  typedef enum logic {
    SCR_MODE_ACTIVE = 1'b0,
    SCR_MODE_RAW    = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/scr_keystream.sv
module scr_keystream #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LFSR_W = 7,
  parameter logic [LFSR_W-1:0] TAPS = 7'b1100000,
  parameter logic [LFSR_W-1:0] SEED = 7'h7F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              sof_i,
  output logic [WORD_W-1:0] ks_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] base;
  logic [LFSR_W-1:0] walk;
  logic [WORD_W-1:0] ks;

  // unrolled WORD_W steps; first generated bit lands in the MSB
  always_comb begin
    base = sof_i ? SEED : state_q;
    walk = base;
    ks   = '0;
    for (int i = 0; i < WORD_W; i++) begin
      ks[WORD_W-1-i] = walk[LFSR_W-1];
      walk = {walk[LFSR_W-2:0], ^(walk & TAPS)};
    end
  end

  assign ks_o = ks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SEED;
    else if (adv_i) state_q <= walk;
  end

  // R4
  state_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_q));

  // R2
  reseed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |-> ks_o[WORD_W-1 -: LFSR_W] == SEED);
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int unsigned WORD_W = SCR_WORD_W,
  parameter int unsigned LANE_W = SCR_LANE_W,
  parameter int unsigned LFSR_W = SCR_LFSR_W,
  parameter logic [LFSR_W-1:0] TAPS = SCR_TAPS,
  parameter logic [LFSR_W-1:0] SEED = SCR_SEED,
  localparam int unsigned LANES = WORD_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic [LANES-1:0]  skip_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  scr_mode_e         mode;
  logic [WORD_W-1:0] ks;
  logic [WORD_W-1:0] mixed;

  assign mode = bypass_i ? SCR_MODE_RAW : SCR_MODE_ACTIVE;

  scr_keystream #(
    .WORD_W(WORD_W),
    .LFSR_W(LFSR_W),
    .TAPS  (TAPS),
    .SEED  (SEED)
  ) u_ks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (valid_i),
    .sof_i (sof_i),
    .ks_o  (ks)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic pass;
    assign pass = skip_i[k] || (mode == SCR_MODE_RAW);
    assign mixed[k*LANE_W +: LANE_W] = pass ? data_i[k*LANE_W +: LANE_W]
                                            : data_i[k*LANE_W +: LANE_W] ^ ks[k*LANE_W +: LANE_W];

    // R5
    lane_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && skip_i[k] |=> data_o[k*LANE_W +: LANE_W] == $past(data_i[k*LANE_W +: LANE_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= mixed;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R7
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  // R6
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bypass_i |=> data_o == $past(data_i));
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned WORD_W = SCR_WORD_W,
  parameter int unsigned LANE_W = SCR_LANE_W,
  localparam int unsigned LANES = WORD_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              tx_valid_i,
  input  logic              tx_sof_i,
  input  logic [LANES-1:0]  tx_skip_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_data_o,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic [LANES-1:0]  rx_skip_i,
  input  logic [WORD_W-1:0] rx_data_i,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o
);
  scr_datapath #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bypass_i(bypass_i),
    .valid_i (tx_valid_i),
    .sof_i   (tx_sof_i),
    .skip_i  (tx_skip_i),
    .data_i  (tx_data_i),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o)
  );

  // additive scheme: identical path restores the data
  scr_datapath #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bypass_i(bypass_i),
    .valid_i (rx_valid_i),
    .sof_i   (rx_sof_i),
    .skip_i  (rx_skip_i),
    .data_i  (rx_data_i),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o)
  );
endmodule

// File: tb/frame_scrambler_test.sv
module frame_scrambler_test;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 127;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bypass_i = 1'b0;
  logic tx_valid_i = 1'b0, tx_sof_i = 1'b0;
  logic [3:0] tx_skip_i = '0;
  logic [31:0] tx_data_i = '0;
  logic tx_valid_o, rx_valid_o;
  logic [31:0] tx_data_o, rx_data_o;
  logic rx_valid_i = 1'b0, rx_sof_i = 1'b0;
  logic [3:0] rx_skip_i = '0;
  logic [31:0] rx_data_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_scrambler uut (
    .clk_i(clk), .rst_ni(rst_ni), .bypass_i(bypass_i),
    .tx_valid_i(tx_valid_i), .tx_sof_i(tx_sof_i), .tx_skip_i(tx_skip_i), .tx_data_i(tx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i), .rx_skip_i(rx_skip_i), .rx_data_i(rx_data_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit seq [PER];
  int tx_pos = 0, rx_pos = 0;
  logic exp_tx_v = 0, exp_rx_v = 0;
  logic [31:0] exp_tx_d = '0, exp_rx_d = '0;
  logic last_sof = 0;
  logic [3:0] last_skip = '0;
  logic [31:0] d_h1 = '0, d_h2 = '0;
  logic v_h1 = 0, v_h2 = 0, bp_h1 = 0, bp_h2 = 0;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ks_at(input int p);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = seq[(p + i) % PER];
    return r;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] sk);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[k*8 +: 8] = sk[k] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  // one clock: compare outputs, then drive the next inputs and update the model
  task automatic cycle(input logic v, input logic sof, input logic [31:0] d,
                       input logic [3:0] sk, input logic bp, input string tag);
    int base;
    logic [31:0] ks;
    @(negedge clk);
    check(tx_valid_o == exp_tx_v, "R7", "tx_valid", {31'b0, tx_valid_o}, {31'b0, exp_tx_v});
    check(tx_data_o == exp_tx_d, tag, "tx_data", tx_data_o, exp_tx_d);
    check(rx_valid_o == exp_rx_v, "R7", "rx_valid", {31'b0, rx_valid_o}, {31'b0, exp_rx_v});
    check(rx_data_o == exp_rx_d, tag, "rx_data", rx_data_o, exp_rx_d);
    if (v_h2 && bp_h1 == bp_h2)
      check(rx_data_o == d_h2, "R8", "round_trip", rx_data_o, d_h2);

    rx_valid_i = tx_valid_o;
    rx_data_i  = tx_data_o;
    rx_sof_i   = last_sof;
    rx_skip_i  = last_skip;
    tx_valid_i = v; tx_sof_i = sof; tx_skip_i = sk; tx_data_i = d; bypass_i = bp;

    exp_tx_v = v;
    if (v) begin
      base = sof ? 0 : tx_pos;
      ks = ks_at(base);
      exp_tx_d = bp ? d : d ^ (ks & lane_mask(sk));
      tx_pos = (base + 32) % PER;
    end
    exp_rx_v = rx_valid_i;
    if (rx_valid_i) begin
      base = rx_sof_i ? 0 : rx_pos;
      ks = ks_at(base);
      exp_rx_d = bp ? rx_data_i : rx_data_i ^ (ks & lane_mask(rx_skip_i));
      rx_pos = (base + 32) % PER;
    end

    d_h2 = d_h1; v_h2 = v_h1; bp_h2 = bp_h1;
    d_h1 = d;    v_h1 = v;    bp_h1 = bp;
    last_sof = v & sof;
    last_skip = sk;
  endtask

  initial begin
    for (int n = 0; n < PER; n++) seq[n] = (n < 7) ? 1'b1 : (seq[n-7] ^ seq[n-6]);

    repeat (3) @(negedge clk);
    // R9 reset state
    check(!tx_valid_o && !rx_valid_o, "R9", "valid_in_reset",
          {30'b0, tx_valid_o, rx_valid_o}, 32'h0);
    check(tx_data_o == 32'h0 && rx_data_o == 32'h0, "R9", "data_in_reset", tx_data_o | rx_data_o, 32'h0);
    rst_ni = 1'b1;

    // R9 first word after reset uses seed even without frame start
    cycle(1, 0, 32'h0, 4'h0, 0, "R9");
    cycle(0, 0, 32'h0, 4'h0, 0, "R4");
    check(tx_data_o == 32'hFE041851, "R9", "seed_after_reset", tx_data_o, 32'hFE041851);

    // R1 frame start with zero data, then continuation
    cycle(1, 1, 32'h0, 4'h0, 0, "R1");
    cycle(1, 0, 32'h0, 4'h0, 0, "R1");
    check(tx_data_o == 32'hFE041851, "R1", "frame_start_word", tx_data_o, 32'hFE041851);
    for (int i = 0; i < 8; i++) cycle(1, 0, $urandom, 4'h0, 0, "R1");

    // R3/R5 only lane 3 scrambled: first keystream byte lands in bits 31:24
    cycle(1, 1, 32'h0, 4'b0111, 0, "R3");
    cycle(1, 0, 32'h0, 4'h0, 0, "R5");
    check(tx_data_o == 32'hFE000000, "R3", "msb_first", tx_data_o, 32'hFE000000);

    // R4 idle gaps inside a frame
    for (int i = 0; i < 12; i++) cycle((i % 3) != 1, 0, $urandom, 4'h0, 0, "R4");

    // R2 reseed mid stream
    cycle(1, 1, 32'h0, 4'h0, 0, "R2");
    cycle(1, 0, $urandom, 4'h0, 0, "R2");
    check(tx_data_o == 32'hFE041851, "R2", "reseed_mid_frame", tx_data_o, 32'hFE041851);

    // R5 random lane skips
    for (int i = 0; i < 16; i++) cycle(1, i == 0, $urandom, 4'($urandom), 0, "R5");

    // R6 bypass, then back to scrambling on the advanced state
    for (int i = 0; i < 10; i++) cycle(1, 0, $urandom, 4'($urandom), 1, "R6");
    for (int i = 0; i < 6; i++) cycle(1, 0, $urandom, 4'h0, 0, "R6");

    // R8 long loopback with mixed traffic and frames
    for (int i = 0; i < 300; i++)
      cycle(($urandom % 5) != 0, (i % 40) == 0, $urandom, ($urandom % 4 == 0) ? 4'b1000 : 4'h0, 0, "R8");
    for (int i = 0; i < 4; i++) cycle(0, 0, 32'h0, 4'h0, 0, "R4");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule